// File: doc/BRIEF.md
# Grouped Interrupt Flag and Enable Controller

This block gathers sixteen hardware event inputs into four independent groups of four. Each group owns a flag register that latches the rising edges of its sources, and an enable register that masks them. When a group has a bit that is both flagged and enabled, it raises that group's processor interrupt level. The four groups drive levels three to six, one level each.

Software reaches the registers through a byte-wide port with a one-cycle read latency. It acknowledges events by writing ones to the flag register. It changes the mask through a single enable write, in which data bit 7 selects whether the written ones set or clear enable bits. The address decoder sorts each access into one of three kinds: RK_FLAG, RK_ENABLE or RK_NONE. A registered read stage turns the decoded kind into read data on the next clock. Apart from the two registers in each group, the block holds no sequencing state and has no state transitions.

Top module: `irq_grp_ctrl`

## Requirements
- R1: Group g (0 to 3) has its flag register at byte address 0x30 + 0x10*g and its enable register at 0x34 + 0x10*g. Every other address reads as 0x00, and writes to it change nothing.
- R2: A 0-to-1 change on src_in[4*g+b], seen between two clocks, sets flag bit b of group g at the second clock, whether or not that bit is enabled. A source held high does not set the flag again after the flag is cleared.
- R3: A flag-register write clears each flag bit whose data bit (3..0) is 1. The other flag bits are unchanged.
- R4: An enable-register write with data bit 7 = 1 sets each enable bit whose data bit (3..0) is 1. The other enable bits are unchanged.
- R5: An enable-register write with data bit 7 = 0 clears each enable bit whose data bit (3..0) is 1. The other enable bits are unchanged.
- R6: When a source edge and a flag clear reach the same bit in one clock, the flag ends up set.
- R7: irq_lvl[g] is high exactly when the AND of group g's flag and enable bits is nonzero, with no clock delay. Bit 0 of irq_lvl is level 3, bit 1 is level 4, bit 2 is level 5 and bit 3 is level 6.
- R8: A read strobe places the addressed register on rd_data at the next clock, with bits 7..4 zero. rd_data holds its value when no read strobe is given.
- R9: After reset, every flag bit, enable bit, irq_lvl bit and rd_data bit is zero.
- R10: A write to one group leaves the registers of every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid one clock after rd_en |
| src_in | input | 16 | Event sources; bits 4g+3..4g belong to group g |
| irq_lvl | output | 4 | Interrupt level outputs for levels 3 to 6 |

## Verification
The assertions assume that the bus strobes and src_in change only between clock edges and are stable at each rising edge. They also assume that wr_en and rd_en are held low while reset is active, so that the first cycle after reset starts from a known read value. The bench drives every input on the falling clock edge through tasks and keeps both strobes low during reset. Its reference model works from each rising-edge sample, the same view the assertions rely on.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
    // Kind of register selected by a bus address
    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_FLAG   = 2'd1,
        RK_ENABLE = 2'd2
    } reg_kind_e;
endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode
    import irq_grp_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_GROUPS  = 4,
    parameter int GROUP_BASE  = 'h30,
    parameter int STRIDE_LOG2 = 4,
    parameter int ENABLE_OFS  = 4,
    localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [GRP_W-1:0]  grp
);
    localparam logic [ADDR_W-1:0] BASE_HI = ADDR_W'(GROUP_BASE >> STRIDE_LOG2);
    localparam logic [ADDR_W-1:0] LAST_HI = ADDR_W'((GROUP_BASE >> STRIDE_LOG2) + NUM_GROUPS);
    localparam logic [STRIDE_LOG2-1:0] EN_LO = STRIDE_LOG2'(ENABLE_OFS);

    logic [ADDR_W-1:0]      hi;
    logic [STRIDE_LOG2-1:0] lo;

    always_comb begin
        hi   = addr >> STRIDE_LOG2;
        lo   = addr[STRIDE_LOG2-1:0];
        kind = RK_NONE;
        grp  = '0;
        if (hi >= BASE_HI && hi < LAST_HI) begin
            grp = GRP_W'(hi - BASE_HI);
            if (lo == '0)
                kind = RK_FLAG;
            else if (lo == EN_LO)
                kind = RK_ENABLE;
        end
    end
endmodule

// File: rtl/irq_grp_bank.sv
module irq_grp_bank #(
    parameter int SRC_W   = 4,
    parameter int DATA_W  = 8,
    parameter int SET_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src,
    input  logic              flag_wr,
    input  logic              en_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SRC_W-1:0]  flag,
    output logic [SRC_W-1:0]  en,
    output logic              irq
);
    logic [SRC_W-1:0] src_q;
    logic [SRC_W-1:0] rise;
    logic [SRC_W-1:0] wbits;
    logic [SRC_W-1:0] flag_d;
    logic [SRC_W-1:0] en_d;

    assign rise  = src & ~src_q;
    assign wbits = wdata[SRC_W-1:0];

    always_comb begin
        flag_d = (flag & ~(flag_wr ? wbits : '0)) | rise;
        en_d   = en;
        if (en_wr)
            en_d = wdata[SET_BIT] ? (en | wbits) : (en & ~wbits);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            flag  <= '0;
            en    <= '0;
        end else begin
            src_q <= src;
            flag  <= flag_d;
            en    <= en_d;
        end
    end

    assign irq = |(flag & en);

    for (genvar b = 0; b < SRC_W; b++) begin : g_chk
        // R2
        edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(src[b]) && !$past(src_q[b])) |-> flag[b]);
        // R3
        w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(flag_wr) && $past(wdata[b]) && !($past(src[b]) && !$past(src_q[b])))
            |-> !flag[b]);
        // R4
        en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(en_wr) && $past(wdata[SET_BIT]) && $past(wdata[b])) |-> en[b]);
        // R5
        en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(en_wr) && !$past(wdata[SET_BIT]) && $past(wdata[b])) |-> !en[b]);
        // R10
        en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(en_wr)) |-> $stable(en[b]));
    end
endmodule

// File: rtl/irq_grp_ctrl.sv
module irq_grp_ctrl
    import irq_grp_pkg::*;
#(
    parameter int NUM_GROUPS    = 4,
    parameter int SRC_PER_GROUP = 4,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8,
    parameter int GROUP_BASE    = 'h30,
    parameter int STRIDE_LOG2   = 4,
    parameter int ENABLE_OFS    = 4,
    parameter int SET_BIT       = 7,
    localparam int SRC_TOTAL    = NUM_GROUPS * SRC_PER_GROUP,
    localparam int GRP_W        = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [SRC_TOTAL-1:0]  src_in,
    output logic [NUM_GROUPS-1:0] irq_lvl
);
    reg_kind_e          kind;
    logic [GRP_W-1:0]   grp;
    logic [SRC_PER_GROUP-1:0] flag_arr [NUM_GROUPS];
    logic [SRC_PER_GROUP-1:0] en_arr   [NUM_GROUPS];
    logic [DATA_W-1:0]  rd_next;

    irq_grp_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_BASE (GROUP_BASE),
        .STRIDE_LOG2(STRIDE_LOG2),
        .ENABLE_OFS (ENABLE_OFS)
    ) u_dec (
        .addr(addr),
        .kind(kind),
        .grp (grp)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        logic sel;
        assign sel = (grp == GRP_W'(g));

        irq_grp_bank #(
            .SRC_W  (SRC_PER_GROUP),
            .DATA_W (DATA_W),
            .SET_BIT(SET_BIT)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_in[g*SRC_PER_GROUP +: SRC_PER_GROUP]),
            .flag_wr(wr_en && sel && kind == RK_FLAG),
            .en_wr  (wr_en && sel && kind == RK_ENABLE),
            .wdata  (wr_data),
            .flag   (flag_arr[g]),
            .en     (en_arr[g]),
            .irq    (irq_lvl[g])
        );

        // R7
        lvl_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_lvl[g] |-> ((flag_arr[g] & en_arr[g]) != '0));
    end

    // Read path: the decoded kind selects the value to register
    always_comb begin
        rd_next = '0;
        unique case (kind)
            RK_FLAG:   rd_next = DATA_W'(flag_arr[grp]);
            RK_ENABLE: rd_next = DATA_W'(en_arr[grp]);
            RK_NONE:   rd_next = '0;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end

    // R8
    rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:SRC_PER_GROUP] == '0);
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en)) |-> $stable(rd_data));
    // R1
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) && $past(kind) == RK_NONE) |-> rd_data == '0);
endmodule

// File: tb/tb_irq_grp_ctrl.sv
`timescale 1ns/1ps
module tb_irq_grp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [15:0] src_in = 16'h0000;
    logic [3:0]  irq_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_grp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .src_in(src_in), .irq_lvl(irq_lvl)
    );

    // Behavioural reference model
    int m_flag [4];
    int m_en   [4];
    int m_prev [4];
    int m_rd;
    bit started = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int ga, reg_lo, rdv, cur, rise, lvl;
        bit rd_now, wr_now;
        rd_now = rd_en; wr_now = wr_en;
        if (!rst_n) begin
            for (int g = 0; g < 4; g++) begin m_flag[g] = 0; m_en[g] = 0; m_prev[g] = 0; end
            m_rd = 0;
        end else begin
            ga = -1; reg_lo = -1;
            if (addr >= 8'h30 && addr < 8'h70) begin
                ga = addr / 16 - 3;
                reg_lo = addr % 16;
            end
            rdv = 0;
            if (ga >= 0 && reg_lo == 0) rdv = m_flag[ga];
            if (ga >= 0 && reg_lo == 4) rdv = m_en[ga];
            if (rd_now) m_rd = rdv;
            for (int g = 0; g < 4; g++) begin
                cur  = (src_in >> (4*g)) & 15;
                rise = cur & ~m_prev[g] & 15;
                if (wr_now && ga == g && reg_lo == 0)
                    m_flag[g] = m_flag[g] & ~(wr_data & 15);
                m_flag[g] = (m_flag[g] | rise) & 15;
                if (wr_now && ga == g && reg_lo == 4) begin
                    if (wr_data[7]) m_en[g] = (m_en[g] | wr_data) & 15;
                    else            m_en[g] = m_en[g] & ~(wr_data & 15) & 15;
                end
                m_prev[g] = cur;
            end
        end
        started = 1'b1;
        #1;
        lvl = 0;
        for (int g = 0; g < 4; g++) if ((m_flag[g] & m_en[g]) != 0) lvl |= (1 << g);
        check("R7 irq_lvl per cycle", int'(irq_lvl), lvl);
        check("R8 rd_data per cycle", int'(rd_data), m_rd);
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = int'(rd_data);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 irq_lvl after reset", int'(irq_lvl), 0);
        for (int g = 0; g < 4; g++) begin
            rd(8'h30 + 8'(16*g), v); check("R9 flag after reset", v, 0);
            rd(8'h34 + 8'(16*g), v); check("R9 enable after reset", v, 0);
        end
        // mask and clear all
        for (int g = 0; g < 4; g++) begin
            wr(8'h34 + 8'(16*g), 8'h0F);
            wr(8'h30 + 8'(16*g), 8'h0F);
        end
        // R4 set one enable bit
        wr(8'h34, 8'h82);
        rd(8'h34, v); check("R4 enable set bit1", v, 2);
        wr(8'h34, 8'hFF);
        rd(8'h34, v); check("R8 upper bits zero on enable", v, 15);
        // R2 / R7 enabled edge
        @(negedge clk); src_in[1] = 1'b1;
        @(negedge clk);
        check("R7 level 3 raised", int'(irq_lvl[0]), 1);
        rd(8'h30, v); check("R2 flag set by edge", v, 2);
        // R2 disabled source still flags
        @(negedge clk); src_in[6] = 1'b1;
        @(negedge clk);
        check("R2 disabled source no level", int'(irq_lvl[1]), 0);
        rd(8'h40, v); check("R2 flag set while disabled", v, 4);
        // R3 W1C with source still high
        wr(8'h30, 8'h02);
        repeat (2) @(negedge clk);
        check("R3 level drops after clear", int'(irq_lvl[0]), 0);
        rd(8'h30, v); check("R2 held source does not refire", v, 0);
        // R5 clear enable bit 0 only
        wr(8'h34, 8'h01);
        rd(8'h34, v); check("R5 enable clear bit0", v, 14);
        // R6 set wins against simultaneous clear
        @(negedge clk);
        src_in[2] = 1'b1; addr = 8'h30; wr_data = 8'h04; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(8'h30, v); check("R6 set wins", v, 4);
        check("R7 level follows pending", int'(irq_lvl[0]), 1);
        // R1 unmapped addresses
        wr(8'h38, 8'hFF); wr(8'h70, 8'hFF); wr(8'h20, 8'hFF);
        rd(8'h38, v); check("R1 unmapped read zero", v, 0);
        rd(8'h34, v); check("R1 unmapped write no effect", v, 14);
        // R10 group independence
        wr(8'h54, 8'h8F);
        rd(8'h64, v); check("R10 group3 enable untouched", v, 0);
        rd(8'h54, v); check("R4 group2 enable set", v, 15);
        @(negedge clk); src_in[15] = 1'b1;
        @(negedge clk);
        check("R7 level 6 masked", int'(irq_lvl[3]), 0);
        wr(8'h64, 8'h88);
        check("R7 level 6 raised", int'(irq_lvl[3]), 1);
        wr(8'h60, 8'h08);
        check("R3 level 6 dropped", int'(irq_lvl[3]), 0);
        rd(8'h40, v); check("R10 group1 flag untouched", v, 4);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule